// File: doc/BRIEF.md
# Pin bank controller with input inversion and hardware blink

This block controls up to 32 general-purpose pins through a small word-addressed register file. Software picks each pin's direction, sets the level that output pins drive, and can set a pin to flash at a fixed rate instead of driving a static level. Input pins go through a synchroniser and are then optionally inverted per pin. The corrected vector can be read from a read-only register and also appears on a dedicated port for the interrupt logic that sits beside the bank.

A direction bit of one makes a pin an input, so after reset every pin floats. A blinking pin takes its level from a free-running prescaler phase with an even split between high and low, so all blinking pins flash in step. The number of pins, the address width, the blink period and the synchroniser depth are parameters. Elaboration rejects settings outside their legal ranges.

Top module: `gpio_bank_ctl`

## Requirements
- R1: While reset is asserted and right after it, every pin is an input, with pin_oe all zero. Output data, blink enable and inversion are all zero, and read data is zero.
- R2: A write stores the low NPINS bits of req_wdata. Word offsets 0x00, 0x04, 0x08 and 0x0C hold output data, direction, blink enable and inversion. A read at one of these offsets returns the register on rsp_rdata one clock after the request, and rsp_rdata is zero in cycles that follow no read.
- R3: pin_oe[i] is 1 exactly when direction bit i is 0, and an input pin has direction bit 1.
- R4: A read at offset 0x10 returns the synchronised pin level XOR the inversion bit for each pin, so an inversion bit of 1 makes the pin active-low.
- R5: level_o carries the same corrected vector. A change on pin_in reaches it after two rising clock edges.
- R6: A pin whose blink bit is 1 drives the prescaler phase. The phase is 0 after reset and toggles every BLINK_PERIOD/2 clocks, whatever happens on the bus.
- R7: A pin whose blink bit is 0 drives its output data bit on pin_out.
- R8: Writes to offset 0x10, to unmapped offsets and to offsets that are not word-aligned change no register. Reads at such offsets, apart from 0x10, return zero.
- R9: Read-data bits at and above NPINS are always zero, even after writing all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid one clock after a read request |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Level driven on each pin |
| pin_oe | output | NPINS | Output enable per pin |
| level_o | output | NPINS | Synchronised and inverted input vector for interrupt logic |

## Verification
Two things can land on the same clock edge: the prescaler phase toggles, and software rewrites the blink-enable or output register. Both change pin_out. The bench forces this by writing alternating blink-enable masks on every clock across several phase toggles. A behavioural model, updated edge by edge, decides the expected level of each pin from the new mask and the new phase. Inversion changes that coincide with pin changes inside the synchroniser window are judged the same way on level_o and on reads of the level register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int BUS_W = 32;

   // word slot inside the bank (byte offset = slot * 4)
   typedef enum logic [3:0] {
      SLOT_OUT   = 4'd0,
      SLOT_DIR   = 4'd1,
      SLOT_BLINK = 4'd2,
      SLOT_POL   = 4'd3,
      SLOT_LEVEL = 4'd4
   } slot_e;

   localparam int LAST_SLOT = 4;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] st_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) st_q[0] <= '0;
            else        st_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) st_q[s] <= '0;
            else        st_q[s] <= st_q[s-1];
         end
      end
   end

   assign q_o = st_q[STAGES-1];

   // edges since reset, saturating, so the latency check never looks before reset
   logic [1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   if (STAGES == 2) begin : g_chk2
      p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)))
         else $error("synchroniser latency is not two edges");
   end

endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);

   localparam int HALF = PERIOD / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] TERM = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          phase_q;
   logic          tc;

   assign tc = (cnt_q == TERM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (tc) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end

   assign phase_o = phase_q;

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TERM)
      else $error("blink prescaler out of range");

   p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_q) |-> $past(tc))
      else $error("blink phase moved off the terminal count");

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_en,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic [NPINS-1:0]  level_i,
   output logic [NPINS-1:0]  out_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  blink_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [BUS_W-1:0]  rdata_q
);

   localparam int IW = ADDR_W - 2;

   logic [IW-1:0]    idx;
   logic             aligned;
   logic             hit;
   logic             wr_go;
   logic [BUS_W-1:0] rd_word;

   assign idx     = req_addr[ADDR_W-1:2];
   assign aligned = (req_addr[1:0] == 2'b00);
   assign hit     = aligned && (idx <= IW'(LAST_SLOT));
   assign wr_go   = req_en && req_we && aligned;

   always_comb begin
      rd_word = '0;
      if (aligned) begin
         if      (idx == IW'(SLOT_OUT))   rd_word[NPINS-1:0] = out_q;
         else if (idx == IW'(SLOT_DIR))   rd_word[NPINS-1:0] = dir_q;
         else if (idx == IW'(SLOT_BLINK)) rd_word[NPINS-1:0] = blink_q;
         else if (idx == IW'(SLOT_POL))   rd_word[NPINS-1:0] = pol_q;
         else if (idx == IW'(SLOT_LEVEL)) rd_word[NPINS-1:0] = level_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '1;
         blink_q <= '0;
         pol_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (wr_go && idx == IW'(SLOT_OUT))   out_q   <= req_wdata[NPINS-1:0];
         if (wr_go && idx == IW'(SLOT_DIR))   dir_q   <= req_wdata[NPINS-1:0];
         if (wr_go && idx == IW'(SLOT_BLINK)) blink_q <= req_wdata[NPINS-1:0];
         if (wr_go && idx == IW'(SLOT_POL))   pol_q   <= req_wdata[NPINS-1:0];
         rdata_q <= (req_en && !req_we) ? rd_word : '0;
      end
   end

   p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && idx == IW'(SLOT_OUT)) |=> (out_q == $past(req_wdata[NPINS-1:0])))
      else $error("output data write lost");

   p_level_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && req_we && !(hit && idx != IW'(SLOT_LEVEL))) |=>
         ($stable(out_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)))
      else $error("ignored write changed a register");

   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && !req_we && !hit) |=> (rdata_q == '0))
      else $error("unmapped read returned data");

   p_high_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_q >> NPINS) == '0)
      else $error("read data above pin count");

endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
   import gpio_bank_pkg::*;
#(
   parameter int NPINS        = 32,
   parameter int ADDR_W       = 6,
   parameter int BLINK_PERIOD = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_en,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rsp_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  level_o
);

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("NPINS must lie in 1..32");
   end
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 5..16");
   end
   if (BLINK_PERIOD < 2 || (BLINK_PERIOD % 2) != 0) begin : g_bad_period
      $error("BLINK_PERIOD must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q, synced;
   logic             phase;

   gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (synced)
   );

   assign level_o = synced ^ pol_q;

   gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_en    (req_en),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .level_i   (level_o),
      .out_q     (out_q),
      .dir_q     (dir_q),
      .blink_q   (blink_q),
      .pol_q     (pol_q),
      .rdata_q   (rsp_rdata)
   );

   gpio_bank_blink #(.PERIOD(BLINK_PERIOD)) u_blink (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_out[i] = blink_q[i] ? phase : out_q[i];
      assign pin_oe[i]  = ~dir_q[i];
   end

   p_blink_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ {NPINS{phase}}) & blink_q) == '0)
      else $error("blinking pin off phase");

   p_reset_inputs_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0))
      else $error("pin driven straight after reset");

endmodule

// File: tb/tb_gpio_bank_ctl.sv
module tb_gpio_bank_ctl;

   localparam int NP   = 24;
   localparam int AW   = 6;
   localparam int PER  = 8;
   localparam int HALF = PER / 2;
   localparam logic [31:0] MASK = (32'h1 << NP) - 32'h1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_en = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rsp_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, level_o;

   gpio_bank_ctl #(.NPINS(NP), .ADDR_W(AW), .BLINK_PERIOD(PER)) dut (
      .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .level_o(level_o));

   always #4 clk = ~clk;

   int vectors = 0;
   int misses  = 0;

   // behavioural reference state
   logic [31:0] m_out, m_dir, m_blk, m_pol, m_s1, m_s2, m_rd;
   int          m_cnt;
   logic        m_ph;
   string       rd_tag;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic [31:0] nrd;
      logic [3:0]  idx;
      logic        al;
      if (!rst_n) begin
         m_out = 0; m_dir = MASK; m_blk = 0; m_pol = 0;
         m_s1 = 0; m_s2 = 0; m_rd = 0; m_cnt = 0; m_ph = 1'b0;
         rd_tag = "R1";
      end else begin
         idx = req_addr[5:2];
         al  = (req_addr[1:0] == 2'b00);
         nrd = 0;
         rd_tag = "R2";
         if (req_en && !req_we) begin
            if (!al || idx > 4) rd_tag = "R8";
            else if (idx == 4) rd_tag = "R4";
            if (al) case (idx)
               4'd0: nrd = m_out;
               4'd1: nrd = m_dir;
               4'd2: nrd = m_blk;
               4'd3: nrd = m_pol;
               4'd4: nrd = (m_s2 ^ m_pol) & MASK;
               default: nrd = 0;
            endcase
         end
         if (req_en && req_we && al) case (idx)
            4'd0: m_out = req_wdata & MASK;
            4'd1: m_dir = req_wdata & MASK;
            4'd2: m_blk = req_wdata & MASK;
            4'd3: m_pol = req_wdata & MASK;
            default: ;
         endcase
         m_rd = nrd;
         m_s2 = m_s1;
         m_s1 = 32'(pin_in) & MASK;
         if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = ~m_ph; end
         else m_cnt++;
      end
   endtask

   task automatic compare();
      logic [31:0] e_out, e_oe, e_lvl;
      e_out = ((m_blk & {32{m_ph}}) | (~m_blk & m_out)) & MASK;
      e_oe  = ~m_dir & MASK;
      e_lvl = (m_s2 ^ m_pol) & MASK;
      if (!rst_n) begin
         chk("R1", 32'(pin_oe), e_oe);
         chk("R1", 32'(pin_out), e_out);
         chk("R1", rsp_rdata, 32'h0);
      end else begin
         chk("R3", 32'(pin_oe), e_oe);
         chk(((m_blk & MASK) != 0) ? "R6" : "R7", 32'(pin_out), e_out);
         chk("R5", 32'(level_o), e_lvl);
         chk(rd_tag, rsp_rdata & MASK, m_rd & MASK);
         chk("R9", rsp_rdata & ~MASK, 32'h0);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      req_en = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
      cyc();
      req_en = 1'b0; req_we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a);
      req_en = 1'b1; req_we = 1'b0; req_addr = a;
      cyc();
      req_en = 1'b0;
      cyc();
   endtask

   task automatic read_all();
      rd(6'h00); rd(6'h04); rd(6'h08); rd(6'h0C); rd(6'h10);
   endtask

   initial begin
      repeat (3) cyc();                       // R1 during reset
      rst_n = 1'b1;
      read_all();                             // R1 values read back, R2
      wr(6'h00, 32'h00A5_A5A5);               // R2, R7
      wr(6'h04, 32'h00FF_0000);               // R3: low 16 outputs
      read_all();
      pin_in = 24'h12_3456;                   // R5 latency, R4 readback
      cyc(); cyc();
      rd(6'h10);
      wr(6'h0C, 32'h00F0_F0F0);               // R4 inversion
      rd(6'h10);
      pin_in = 24'hFF_00FF;
      wr(6'h0C, 32'h0000_FFFF);               // inversion change while pins move
      rd(6'h10);
      wr(6'h10, 32'hFFFF_FFFF);               // R8 data-in write ignored
      wr(6'h20, 32'hFFFF_FFFF);               // R8 unmapped write
      wr(6'h01, 32'hFFFF_FFFF);               // R8 misaligned write
      read_all();
      rd(6'h14); rd(6'h3C); rd(6'h02);        // R8 zero reads
      wr(6'h00, 32'hFFFF_FFFF);               // R9 upper bits dropped
      rd(6'h00);
      wr(6'h00, 32'h0000_0000);
      wr(6'h08, 32'h0000_00F0);               // R6 blink on four pins
      repeat (20) cyc();
      for (int k = 0; k < 12; k++) begin      // blink toggle vs mask write
         wr(6'h08, (k % 2 == 0) ? 32'h0000_000F : 32'h0000_0003);
         if (k % 3 == 0) wr(6'h00, 32'h0000_0005 << k);
      end
      wr(6'h08, 32'h0);                        // R7 static again
      repeat (6) cyc();
      for (int k = 0; k < 40; k++) begin      // R5 patterns on inputs
         pin_in = 24'(32'h9E37_79B9 * (k + 1));
         if (k % 5 == 0) wr(6'h0C, 32'(k * 32'h0101_0101));
         else cyc();
         if (k % 7 == 0) rd(6'h10);
      end
      wr(6'h04, 32'hFFFF_FFFF);               // R3 all inputs
      rd(6'h04);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule